// File: doc/BRIEF.md
# Message-Signaled Interrupt File

This block keeps the interrupt state of one privilege level of one hart. Each interrupt identity from 1 up to a configurable count has one pending bit and one enable bit. A device raises an interrupt by writing the identity number as a 32-bit value to the set-pending offset of the block's 4 KiB page. The hart sees one interrupt line. That line is driven when delivery is on and some eligible identity is both pending and enabled.

Software reaches the state through two steps. It first loads a register number into a select register. It then reads, writes, sets bits of, or clears bits of the selected register through a data port. A separate top-identity port always reports the winning identity. A write to that port claims the identity, which clears its pending bit in the same update.

Priority is fixed by number, and the lowest identity wins. A threshold register can hide every identity at or above a chosen value.

Top module: `msi_intr_file`

## Requirements
- R1: After reset, every pending bit, every enable bit, the delivery register and the threshold register are zero, irq is low and topei reads 0.
- R2: A data access with op code 1 (write) replaces the selected register, op 2 (set) ORs the data into it, and op 3 (clear) clears the bits that are 1 in the data. reg_rdata always shows the register selected at that moment.
- R3: Select 0x70 is the delivery register, and only bit 0 is stored. A value of 1 allows irq and a value of 0 holds irq low.
- R4: Select 0x72 is an 11-bit threshold. A value of 0 does no filtering. A nonzero value N excludes every identity >= N from selection, so N = 1 hides all identities.
- R5: Pending word k sits at select 0x80+k and enable word k sits at select 0xC0+k. Identity i is bit i%32 of word i/32.
- R6: The bits for identity 0, and for identities above NUM_IDS, always read 0 and cannot be set.
- R7: topei carries the lowest identity that is pending, enabled and not excluded by the threshold. It appears in bits 26:16 and again in bits 10:0, and all other bits are zero. The value is 0 when no identity qualifies.
- R8: A claim pulse clears the pending bit of the identity that topei reports. A claim while topei is 0 changes nothing.
- R9: A message write with address 0x000 and a value v in 1..NUM_IDS sets pending bit v on the next clock. A value of 0, a value above NUM_IDS, or any other address is ignored.
- R10: irq is high exactly when delivery is enabled and topei is nonzero.
- R11: A select number that is not implemented reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Load the select register |
| sel_wdata | input | 8 | New register number |
| reg_we | input | 1 | Perform a data operation on the selected register |
| reg_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| reg_wdata | input | 32 | Operand for the data operation |
| reg_rdata | output | 32 | Current value of the selected register |
| claim_we | input | 1 | Claim the reported identity |
| topei | output | 32 | Top identity (26:16) and its priority (10:0) |
| msg_we | input | 1 | Message write strobe |
| msg_addr | input | 12 | Byte offset within the page |
| msg_wdata | input | 32 | Identity to make pending |
| irq | output | 1 | Interrupt request to the hart |

## Verification
A wrong pending or enable bit shows up in the same cycle. It changes topei and irq, and it changes the word read back through the select path. A selection or threshold error shows up as the wrong identity on topei right after the state update that caused it. A broken claim shows up one clock after the claim pulse. At that point topei still reports the claimed identity, or the pending word still has its bit set.

// File: rtl/mif_pkg.sv
package mif_pkg;

    localparam int ID_W = 11;

    localparam logic [7:0] SEL_DELIV     = 8'h70;
    localparam logic [7:0] SEL_THRESH    = 8'h72;
    localparam logic [7:0] SEL_PEND_BASE = 8'h80;
    localparam logic [7:0] SEL_EN_BASE   = 8'hC0;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } reg_op_e;

    function automatic logic [31:0] apply_op(reg_op_e op, logic [31:0] old_v, logic [31:0] arg);
        case (op)
            OP_WRITE: apply_op = arg;
            OP_SET:   apply_op = old_v | arg;
            OP_CLEAR: apply_op = old_v & ~arg;
            default:  apply_op = old_v;
        endcase
    endfunction

endpackage

// File: rtl/mif_msg_dec.sv
module mif_msg_dec #(
    parameter int NUM_IDS = 63,
    parameter int TOT     = 64
) (
    input  logic            msg_we,
    input  logic [11:0]     msg_addr,
    input  logic [31:0]     msg_wdata,
    output logic [TOT-1:0]  set_vec
);
    logic hit;

    always_comb begin
        hit = msg_we && (msg_addr == 12'h000) && (msg_wdata != 32'd0)
              && (msg_wdata <= 32'(NUM_IDS));
        set_vec = '0;
        for (int i = 1; i < TOT; i++) begin
            if (hit && (msg_wdata == 32'(i)) && (i <= NUM_IDS))
                set_vec[i] = 1'b1;
        end
    end
endmodule

// File: rtl/mif_prio.sv
module mif_prio
    import mif_pkg::*;
#(
    parameter int NUM_IDS = 63,
    parameter int TOT     = 64
) (
    input  logic [TOT-1:0]  cand,
    input  logic [ID_W-1:0] thresh,
    output logic [ID_W-1:0] top_id
);
    always_comb begin
        top_id = '0;
        for (int i = NUM_IDS; i >= 1; i--) begin
            if (cand[i] && ((thresh == '0) || (i < int'(thresh))))
                top_id = ID_W'(i);
        end
    end
endmodule

// File: rtl/msi_intr_file.sv
module msi_intr_file
    import mif_pkg::*;
#(
    parameter int NUM_IDS = 63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_we,
    input  logic [7:0]  sel_wdata,
    input  logic        reg_we,
    input  logic [1:0]  reg_op,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        claim_we,
    output logic [31:0] topei,
    input  logic        msg_we,
    input  logic [11:0] msg_addr,
    input  logic [31:0] msg_wdata,
    output logic        irq
);
    localparam int NB  = NUM_IDS + 1;
    localparam int NW  = (NB + 31) / 32;
    localparam int TOT = NW * 32;

    function automatic logic [TOT-1:0] make_mask();
        logic [TOT-1:0] m;
        for (int i = 0; i < TOT; i++)
            m[i] = (i >= 1) && (i <= NUM_IDS);
        return m;
    endfunction

    localparam logic [TOT-1:0] VMASK = make_mask();

    typedef struct packed {
        logic [7:0]      sel;
        logic            deliv;
        logic [ID_W-1:0] thr;
        logic [TOT-1:0]  pend;
        logic [TOT-1:0]  en;
    } state_t;

    state_t          s_d, s_q;
    logic [TOT-1:0]  set_vec;
    logic [ID_W-1:0] top_id;
    reg_op_e         op;

    assign op = reg_op_e'(reg_op);

    mif_msg_dec #(.NUM_IDS(NUM_IDS), .TOT(TOT)) u_dec (
        .msg_we    (msg_we),
        .msg_addr  (msg_addr),
        .msg_wdata (msg_wdata),
        .set_vec   (set_vec)
    );

    mif_prio #(.NUM_IDS(NUM_IDS), .TOT(TOT)) u_prio (
        .cand   (s_q.pend & s_q.en),
        .thresh (s_q.thr),
        .top_id (top_id)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (s_q.sel == SEL_DELIV)
            reg_rdata = {31'd0, s_q.deliv};
        else if (s_q.sel == SEL_THRESH)
            reg_rdata = {21'd0, s_q.thr};
        for (int w = 0; w < NW; w++) begin
            if (s_q.sel == 8'(int'(SEL_PEND_BASE) + w))
                reg_rdata = s_q.pend[w*32 +: 32];
            if (s_q.sel == 8'(int'(SEL_EN_BASE) + w))
                reg_rdata = s_q.en[w*32 +: 32];
        end
    end

    // next state
    always_comb begin
        logic [31:0] tmp;
        s_d = s_q;
        tmp = '0;
        if (sel_we)
            s_d.sel = sel_wdata;
        if (reg_we && (op != OP_READ)) begin
            if (s_q.sel == SEL_DELIV) begin
                tmp = apply_op(op, {31'd0, s_q.deliv}, reg_wdata);
                s_d.deliv = tmp[0];
            end else if (s_q.sel == SEL_THRESH) begin
                tmp = apply_op(op, {21'd0, s_q.thr}, reg_wdata);
                s_d.thr = tmp[ID_W-1:0];
            end
            for (int w = 0; w < NW; w++) begin
                if (s_q.sel == 8'(int'(SEL_PEND_BASE) + w))
                    s_d.pend[w*32 +: 32] = apply_op(op, s_q.pend[w*32 +: 32], reg_wdata);
                if (s_q.sel == 8'(int'(SEL_EN_BASE) + w))
                    s_d.en[w*32 +: 32] = apply_op(op, s_q.en[w*32 +: 32], reg_wdata);
            end
        end
        if (claim_we && (top_id != '0)) begin
            for (int i = 1; i < TOT; i++)
                if (top_id == ID_W'(i))
                    s_d.pend[i] = 1'b0;
        end
        s_d.pend = (s_d.pend | set_vec) & VMASK;
        s_d.en   = s_d.en & VMASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign topei = {5'd0, top_id, 5'd0, top_id};
    assign irq   = s_q.deliv && (top_id != '0);

endmodule

// File: rtl/msi_intr_file_chk.sv
module msi_intr_file_chk #(
    parameter int NUM_IDS = 63
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic [31:0] topei,
    input logic        deliv,
    input logic [10:0] thr,
    input logic        claim_we,
    input logic        reg_we,
    input logic        msg_we
);
    a_r7_topei_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (topei[26:16] == topei[10:0]) && (topei[31:27] == 5'd0) && (topei[15:11] == 5'd0));

    a_r10_irq_needs_deliv: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> deliv);

    a_r10_irq_needs_top: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (topei[26:16] != 11'd0));

    a_r4_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr != 11'd0) && (topei[26:16] != 11'd0)) |-> (topei[26:16] < thr));

    a_r6_top_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(topei[26:16]) <= NUM_IDS);

    a_r8_claim_moves_top: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_we && (topei[26:16] != 11'd0) && !reg_we && !msg_we)
        |=> (topei[26:16] != $past(topei[26:16])));
endmodule

bind msi_intr_file msi_intr_file_chk #(.NUM_IDS(NUM_IDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .topei    (topei),
    .deliv    (s_q.deliv),
    .thr      (s_q.thr),
    .claim_we (claim_we),
    .reg_we   (reg_we),
    .msg_we   (msg_we)
);

// File: tb/msi_intr_file_test.sv
module msi_intr_file_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 1'b0;
    logic [7:0]  sel_wdata = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_op = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        claim_we = 1'b0;
    logic [31:0] topei;
    logic        msg_we = 1'b0;
    logic [11:0] msg_addr = '0;
    logic [31:0] msg_wdata = '0;
    logic        irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    msi_intr_file #(.NUM_IDS(63)) uut (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .reg_we(reg_we), .reg_op(reg_op), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .claim_we(claim_we), .topei(topei), .msg_we(msg_we), .msg_addr(msg_addr),
        .msg_wdata(msg_wdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic csr(input logic [7:0] s, input logic [1:0] op, input logic [31:0] w);
        @(negedge clk); sel_we = 1'b1; sel_wdata = s;
        @(negedge clk); sel_we = 1'b0; reg_we = 1'b1; reg_op = op; reg_wdata = w;
        @(negedge clk); reg_we = 1'b0; reg_op = 2'd0;
    endtask

    task automatic rd(input logic [7:0] s, output logic [31:0] v);
        @(negedge clk); sel_we = 1'b1; sel_wdata = s;
        @(negedge clk); sel_we = 1'b0; v = reg_rdata;
    endtask

    task automatic msg(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); msg_we = 1'b1; msg_addr = a; msg_wdata = v;
        @(negedge clk); msg_we = 1'b0;
    endtask

    task automatic claim();
        @(negedge clk); claim_we = 1'b1;
        @(negedge clk); claim_we = 1'b0;
    endtask

    function automatic logic [31:0] tv(input int id);
        return (32'(id) << 16) | 32'(id);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 topei", topei, 32'd0);
        rd(8'h70, v); check("R1 deliv", v, 32'd0);
        rd(8'h72, v); check("R1 thresh", v, 32'd0);
        rd(8'h80, v); check("R1 pend0", v, 32'd0);
        rd(8'hC0, v); check("R1 en0", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        csr(8'hC0, 2'd1, 32'hFFFF_FFFF); rd(8'hC0, v); check("R6 id0 en", v, 32'hFFFF_FFFE);
        csr(8'hC0, 2'd3, 32'h0000_00F0); rd(8'hC0, v); check("R2 clear", v, 32'hFFFF_FF0E);
        csr(8'hC0, 2'd2, 32'h0000_0010); rd(8'hC0, v); check("R2 set", v, 32'hFFFF_FF1E);
        csr(8'hC0, 2'd2, 32'h0000_00E0); rd(8'hC0, v); check("R2 set back", v, 32'hFFFF_FFFE);
        csr(8'hC1, 2'd1, 32'hFFFF_FFFF); rd(8'hC1, v); check("R5 en1", v, 32'hFFFF_FFFF);
        csr(8'h80, 2'd2, 32'h0000_0004); check("R5 pend via csr", topei, tv(2));
        csr(8'h80, 2'd3, 32'h0000_0004); check("R2 pend clear", topei, 32'd0);
    endtask

    task automatic t_msg();
        logic [31:0] v;
        msg(12'h000, 32'd5);
        rd(8'h80, v); check("R9 set 5", v, 32'h0000_0020);
        check("R7 top 5", topei, tv(5));
        check("R10 no deliv", {31'd0, irq}, 32'd0);
        msg(12'h000, 32'd0);
        msg(12'h000, 32'd64);
        msg(12'h004, 32'd7);
        rd(8'h80, v); check("R9 ignored w0", v, 32'h0000_0020);
        rd(8'h81, v); check("R9 ignored w1", v, 32'd0);
        msg(12'h000, 32'd33);
        rd(8'h81, v); check("R9 set 33", v, 32'h0000_0002);
        check("R7 still 5", topei, tv(5));
    endtask

    task automatic t_deliv();
        logic [31:0] v;
        csr(8'h70, 2'd1, 32'd1);
        check("R10 irq on", {31'd0, irq}, 32'd1);
        rd(8'h70, v); check("R3 deliv rd", v, 32'd1);
        msg(12'h000, 32'd3);
        check("R7 lowest 3", topei, tv(3));
    endtask

    task automatic t_thr();
        logic [31:0] v;
        csr(8'h72, 2'd1, 32'd4);
        check("R4 thr4", topei, tv(3));
        rd(8'h72, v); check("R4 thr rd", v, 32'd4);
        csr(8'h72, 2'd1, 32'd3);
        check("R4 thr3", topei, 32'd0);
        check("R10 irq thr3", {31'd0, irq}, 32'd0);
        csr(8'h72, 2'd1, 32'd1);
        check("R4 thr1", topei, 32'd0);
        csr(8'h72, 2'd1, 32'd0);
        check("R4 thr off", topei, tv(3));
    endtask

    task automatic t_claim();
        logic [31:0] v;
        claim();
        rd(8'h80, v); check("R8 clear 3", v, 32'h0000_0020);
        check("R8 next 5", topei, tv(5));
        claim();
        check("R8 next 33", topei, tv(33));
        claim();
        check("R8 empty", topei, 32'd0);
        check("R10 irq empty", {31'd0, irq}, 32'd0);
        rd(8'h81, v); check("R8 w1 clr", v, 32'd0);
        claim();
        rd(8'h80, v); check("R8 idle claim", v, 32'd0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        msg(12'h000, 32'd10);
        check("R7 top 10", topei, tv(10));
        csr(8'hC0, 2'd3, 32'h0000_0400);
        check("R7 masked", topei, 32'd0);
        rd(8'h80, v); check("R5 pend kept", v, 32'h0000_0400);
        csr(8'hC0, 2'd2, 32'h0000_0400);
        check("R7 unmasked", topei, tv(10));
        csr(8'h70, 2'd1, 32'd0);
        check("R3 deliv off", {31'd0, irq}, 32'd0);
        check("R3 top kept", topei, tv(10));
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        csr(8'h71, 2'd1, 32'hFFFF_FFFF);
        rd(8'h71, v); check("R11 rd 71", v, 32'd0);
        rd(8'h70, v); check("R11 70 intact", v, 32'd0);
        csr(8'h82, 2'd1, 32'h0000_00FF);
        rd(8'h82, v); check("R11 rd 82", v, 32'd0);
        rd(8'h80, v); check("R11 80 intact", v, 32'h0000_0400);
        rd(8'h40, v); check("R11 rd 40", v, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_msg();
        t_deliv();
        t_thr();
        t_claim();
        t_mask();
        t_unimpl();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule